// File: doc/BRIEF.md
# ECC RAM Error Monitor with Threshold

This block wraps a single-port word memory of 64-bit data words. Every word carries an 8-bit SECDED check field: seven Hamming parity bits plus one overall parity bit. Reads correct any single-bit fault in the data returned to the bus. A double-bit fault instead yields a bus error response. A small register window lets software set how many corrected faults are tolerated before a correctable-error level is raised toward an external error collector. Uncorrectable faults raise a second level and record the failing word index.

The bus address is split by its two top bits into windows. Window 0 is the data array. Window 1 is an alias that reaches the check field of the same word index, one array depth above the data base. Window 2 holds the registers, selected by the low three address bits. Window 3 reads zero. Test software injects a fault by opening the alias write gate in the control register and writing a check field that differs from the encoded one. A later ordinary data write re-encodes the word and removes the fault.

A request is presented for one cycle. A read answers with `bus_rvalid` in the cycle that follows.

Top module: `ecc_ram_monitor`

## Requirements
- R1: After reset, `err_corr_o`, `err_uncorr_o` and `bus_rvalid` are low, and every register reads zero.
- R2: A data-window write stores the word and freshly encoded check bits, and gives no `bus_rvalid`. A data-window read returns the word, with `bus_rvalid` high and `bus_rerr` low, exactly one cycle after the request.
- R3: A read through the check alias window (address top bits 01) returns the raw stored 8-bit check field in bits [7:0] and zeros above. It performs no checking or correction and changes no counter or status.
- R4: A write through the check alias window replaces the stored check field only while bit 8 of the control register (register 0) is 1. Otherwise it is ignored.
- R5: A data read whose stored check field differs from the encoded value in exactly one bit returns the original data with `bus_rerr` low. The fault stays in the array, so later reads see it again.
- R6: The occurrence counter (register 2) adds one on every corrected data read and holds at 2^CNT_W-1. A software write loads the written value, so writing 0 clears it.
- R7: Status bit 0 (register 4) is set by a corrected read when bit 0 of the interrupt-control register (register 3) is 1, the threshold (register 1) is nonzero, and the counter after the increment is at or above the threshold. `err_corr_o` equals status bit 0. Writing 1 to the bit clears it, and writing 0 leaves it unchanged.
- R8: A data read whose check field differs in two bits returns `bus_rerr` high with zero data. In the cycle after that response, the word index is in register 5 and status bit 1 is set. `err_uncorr_o` equals status bit 1, and writing 1 to that bit clears it.
- R9: The register map is: 0 control (16 bits), 1 threshold, 2 counter, 3 interrupt control (bit 0), 4 status (bit 1 uncorrectable, bit 0 correctable), 5 failing index (read-only). Indices 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+2 | Window in the top two bits, word or register index below |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 64 | Read response data |
| bus_rerr | output | 1 | Read response carries an uncorrectable fault |
| err_corr_o | output | 1 | Correctable-error level to the collector |
| err_uncorr_o | output | 1 | Uncorrectable-error level to the collector |

## Verification
A corrupted counter or threshold compare shows up as `err_corr_o` rising one read too early or too late. That is visible on the clock edge after the faulty read's response. A wrong syndrome decode shows up on the response itself, in the cycle after the request, as wrong data or a spurious `bus_rerr`. A check-field write that leaks past the closed gate stays hidden until the next read of that word. That read then shows a correction or an error that should not exist, and an alias read shows the changed raw value.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;
  localparam int DATA_W   = 64;
  localparam int HAM_W    = 7;
  localparam int CHK_W    = HAM_W + 1;
  localparam int CODE_TOP = DATA_W + HAM_W;

  typedef enum logic [1:0] {WIN_DATA = 2'd0, WIN_CHECK = 2'd1, WIN_REGS = 2'd2, WIN_NONE = 2'd3} win_e;
  typedef enum logic [1:0] {ECC_CLEAN = 2'd0, ECC_SINGLE = 2'd1, ECC_DOUBLE = 2'd2} ecc_class_e;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Hamming parity: each data bit sits at the next non-power-of-two code position
  function automatic logic [HAM_W-1:0] ham_parity(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] p;
    int k;
    p = '0;
    k = 0;
    for (int pos = 1; pos <= CODE_TOP; pos++) begin
      if (!is_pow2(pos)) begin
        if (d[k]) p = p ^ HAM_W'(pos);
        k++;
      end
    end
    return p;
  endfunction

  function automatic logic [CHK_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] p;
    p = ham_parity(d);
    return {(^d) ^ (^p), p};
  endfunction

  // Data bit that a syndrome points at, as a one-hot mask (zero for check-bit positions)
  function automatic logic [DATA_W-1:0] flip_mask(input logic [HAM_W-1:0] s);
    logic [DATA_W-1:0] m;
    int k;
    m = '0;
    k = 0;
    for (int pos = 1; pos <= CODE_TOP; pos++) begin
      if (!is_pow2(pos)) begin
        if (HAM_W'(pos) == s) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_store.sv
module ecc_store
  import ecc_mon_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              we_data,
  input  logic              we_chk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CHK_W-1:0]  wchk,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [CHK_W-1:0]  mem_c [DEPTH];

  always_ff @(posedge clk) begin
    if (we_data) begin
      mem_d[idx] <= wdata;
      mem_c[idx] <= ecc_encode(wdata);
    end else if (we_chk) begin
      mem_c[idx] <= wchk;
    end
    if (rd_en) begin
      rd_data <= mem_d[idx];
      rd_chk  <= mem_c[idx];
    end
  end
endmodule

// File: rtl/secded_check.sv
module secded_check
  import ecc_mon_pkg::*;
(
  input  logic [DATA_W-1:0] raw_data,
  input  logic [CHK_W-1:0]  raw_chk,
  output logic [DATA_W-1:0] fixed_data,
  output ecc_class_e        cls
);
  logic [HAM_W-1:0] syndrome;
  logic             parity_odd;

  assign syndrome   = raw_chk[HAM_W-1:0] ^ ham_parity(raw_data);
  assign parity_odd = ^{raw_data, raw_chk};

  always_comb begin
    if (!parity_odd) cls = (syndrome == '0) ? ECC_CLEAN : ECC_DOUBLE;
    else             cls = (syndrome > HAM_W'(CODE_TOP)) ? ECC_DOUBLE : ECC_SINGLE;
  end

  assign fixed_data = raw_data ^ ((cls == ECC_SINGLE) ? flip_mask(syndrome) : '0);
endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs #(
  parameter int CNT_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_idx,
  input  logic [15:0]      reg_wdata,
  input  logic             ce_evt,
  input  logic             ue_evt,
  input  logic [IDX_W-1:0] evt_idx,
  output logic [63:0]      reg_rdata,
  output logic             chk_wr_en,
  output logic             ce_flag,
  output logic             ue_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [2:0] RG_CTRL = 3'd0, RG_THR = 3'd1, RG_CNT = 3'd2,
                         RG_IRQ  = 3'd3, RG_STAT = 3'd4, RG_UEIX = 3'd5;

  logic [15:0]      ctrl_q;
  logic [CNT_W-1:0] thr_q, cnt_q, cnt_after;
  logic             irq_q, ce_q, ue_q, reach;
  logic [IDX_W-1:0] ue_idx_q;
  logic             wr_ctrl, wr_thr, wr_cnt, wr_irq, wr_stat;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign wr_ctrl   = reg_we && reg_idx == RG_CTRL;
  assign wr_thr    = reg_we && reg_idx == RG_THR;
  assign wr_cnt    = reg_we && reg_idx == RG_CNT;
  assign wr_irq    = reg_we && reg_idx == RG_IRQ;
  assign wr_stat   = reg_we && reg_idx == RG_STAT;
  assign cnt_after = sat_inc(cnt_q);
  assign reach     = irq_q && thr_q != '0 && cnt_after >= thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      thr_q    <= '0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
      ce_q     <= 1'b0;
      ue_q     <= 1'b0;
      ue_idx_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (wr_thr)  thr_q  <= reg_wdata[CNT_W-1:0];
      if (wr_cnt)      cnt_q <= reg_wdata[CNT_W-1:0];
      else if (ce_evt) cnt_q <= cnt_after;
      if (wr_irq)  irq_q  <= reg_wdata[0];
      if (ce_evt && reach)             ce_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) ce_q <= 1'b0;
      if (ue_evt)                      ue_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) ue_q <= 1'b0;
      if (ue_evt) ue_idx_q <= evt_idx;
    end
  end

  always_comb begin
    case (reg_idx)
      RG_CTRL: reg_rdata = {48'd0, ctrl_q};
      RG_THR:  reg_rdata = {{(64-CNT_W){1'b0}}, thr_q};
      RG_CNT:  reg_rdata = {{(64-CNT_W){1'b0}}, cnt_q};
      RG_IRQ:  reg_rdata = {63'd0, irq_q};
      RG_STAT: reg_rdata = {62'd0, ue_q, ce_q};
      RG_UEIX: reg_rdata = {{(64-IDX_W){1'b0}}, ue_idx_q};
      default: reg_rdata = '0;
    endcase
  end

  assign chk_wr_en = ctrl_q[8];
  assign ce_flag   = ce_q;
  assign ue_flag   = ue_q;

  a_r6_cnt_holds_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CNT_MAX && !$past(wr_cnt)) |-> cnt_q == CNT_MAX);
  a_r6_cnt_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !wr_cnt && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  a_r7_flag_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_q) |-> ($past(ce_evt) && $past(irq_q)));
  a_r7_flag_fall_needs_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_q) |-> $past(wr_stat && reg_wdata[0]));
  a_r8_fail_index_captured: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> (ue_q && ue_idx_q == $past(evt_idx)));
endmodule

// File: rtl/ecc_ram_monitor.sv
module ecc_ram_monitor
  import ecc_mon_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [IDX_W+1:0]  bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  output logic              bus_rerr,
  output logic              err_corr_o,
  output logic              err_uncorr_o
);
  localparam int ADDR_W = IDX_W + 2;

  win_e              win, pend_win;
  logic [IDX_W-1:0]  idx, pend_idx;
  logic              pend_rd;
  logic [63:0]       pend_reg_q, reg_rdata;
  logic              chk_wr_en;
  logic              st_we_data, st_we_chk, st_rd_en, reg_we;
  logic [DATA_W-1:0] raw_data, fixed_data;
  logic [CHK_W-1:0]  raw_chk;
  ecc_class_e        cls;
  logic              ce_evt, ue_evt;

  assign win = win_e'(bus_addr[ADDR_W-1 -: 2]);
  assign idx = bus_addr[IDX_W-1:0];

  assign st_we_data = bus_req && bus_we && win == WIN_DATA;
  assign st_we_chk  = bus_req && bus_we && win == WIN_CHECK && chk_wr_en;
  assign st_rd_en   = bus_req && !bus_we && (win == WIN_DATA || win == WIN_CHECK);
  assign reg_we     = bus_req && bus_we && win == WIN_REGS;

  ecc_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .we_data(st_we_data), .we_chk(st_we_chk), .rd_en(st_rd_en),
    .idx(idx), .wdata(bus_wdata), .wchk(bus_wdata[CHK_W-1:0]),
    .rd_data(raw_data), .rd_chk(raw_chk)
  );

  secded_check u_check (
    .raw_data(raw_data), .raw_chk(raw_chk), .fixed_data(fixed_data), .cls(cls)
  );

  ecc_err_regs #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(idx[2:0]),
    .reg_wdata(bus_wdata[15:0]), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .evt_idx(pend_idx), .reg_rdata(reg_rdata), .chk_wr_en(chk_wr_en),
    .ce_flag(err_corr_o), .ue_flag(err_uncorr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_rd    <= 1'b0;
      pend_win   <= WIN_DATA;
      pend_idx   <= '0;
      pend_reg_q <= '0;
    end else begin
      pend_rd <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        pend_win   <= win;
        pend_idx   <= idx;
        pend_reg_q <= reg_rdata;
      end
    end
  end

  assign ce_evt = pend_rd && pend_win == WIN_DATA && cls == ECC_SINGLE;
  assign ue_evt = pend_rd && pend_win == WIN_DATA && cls == ECC_DOUBLE;

  always_comb begin
    bus_rvalid = pend_rd;
    bus_rerr   = 1'b0;
    case (pend_win)
      WIN_DATA: begin
        bus_rerr  = pend_rd && cls == ECC_DOUBLE;
        bus_rdata = (cls == ECC_DOUBLE) ? '0 : fixed_data;
      end
      WIN_CHECK: bus_rdata = {{(64-CHK_W){1'b0}}, raw_chk};
      WIN_REGS:  bus_rdata = pend_reg_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_ecc_ram_monitor.sv
module sim_ecc_ram_monitor;
  localparam int IDX_W = 4;
  localparam int CNT_W = 8;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] W_DATA = 2'd0, W_CHK = 2'd1, W_REG = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [IDX_W+1:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic bus_rvalid, bus_rerr, err_corr_o, err_uncorr_o;
  logic [63:0] bus_rdata;

  int checks = 0, failures = 0;
  bit cmp_on = 0, done = 0;

  // behavioural model
  logic [63:0] m_data [DEPTH];
  logic [7:0]  m_mask [DEPTH];
  logic [7:0]  m_good [DEPTH];
  bit          m_known [DEPTH];
  logic [15:0] m_ctrl = '0;
  int          m_thr = 0, m_cnt = 0, m_ueidx = 0;
  bit          m_irq = 0, m_ce = 0, m_ue = 0;

  always #5 clk = ~clk;

  ecc_ram_monitor #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .bus_rerr(bus_rerr), .err_corr_o(err_corr_o), .err_uncorr_o(err_uncorr_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] exp_reg(input int r);
    case (r)
      0: return {48'd0, m_ctrl};
      1: return 64'(m_thr);
      2: return 64'(m_cnt);
      3: return {63'd0, m_irq};
      4: return {62'd0, m_ue, m_ce};
      5: return 64'(m_ueidx);
      default: return '0;
    endcase
  endfunction

  // every clock: error levels against the model (R7, R8)
  always @(negedge clk) if (cmp_on) begin
    chk(err_corr_o == m_ce, "R7 err_corr_o", 64'(err_corr_o), 64'(m_ce));
    chk(err_uncorr_o == m_ue, "R8 err_uncorr_o", 64'(err_uncorr_o), 64'(m_ue));
  end

  task automatic bus_op(input bit we, input logic [1:0] win, input int ix,
                        input logic [63:0] wd, input string tag);
    logic [63:0] exp_d;
    bit exp_e, exp_known;
    int pc;
    pc = $countones(m_mask[ix]);
    exp_e = 0; exp_known = 1; exp_d = '0;
    if (win == W_DATA) begin
      exp_e = pc >= 2;
      exp_d = exp_e ? '0 : m_data[ix];
    end else if (win == W_CHK) begin
      exp_known = m_known[ix];
      exp_d = {56'd0, m_good[ix] ^ m_mask[ix]};
    end else if (win == W_REG) exp_d = exp_reg(ix & 7);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = {win, IDX_W'(ix)}; bus_wdata = wd;
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
    if (we) begin
      if (win == W_DATA) begin m_data[ix] = wd; m_mask[ix] = '0; m_known[ix] = 0; end
      else if (win == W_CHK && m_ctrl[8]) m_mask[ix] = wd[7:0] ^ m_good[ix];
      else if (win == W_REG) case (ix & 7)
        0: m_ctrl = wd[15:0];
        1: m_thr = int'(wd[CNT_W-1:0]);
        2: m_cnt = int'(wd[CNT_W-1:0]);
        3: m_irq = wd[0];
        4: begin if (wd[0]) m_ce = 0; if (wd[1]) m_ue = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(bus_rvalid == !we, {tag, " rvalid"}, 64'(bus_rvalid), 64'(!we));
    if (!we) begin
      chk(bus_rerr == exp_e, {tag, " rerr"}, 64'(bus_rerr), 64'(exp_e));
      if (exp_known) chk(bus_rdata == exp_d, {tag, " rdata"}, bus_rdata, exp_d);
      else begin
        chk(bus_rdata[63:8] == '0, {tag, " raw upper"}, bus_rdata, '0);
        m_good[ix] = bus_rdata[7:0]; m_known[ix] = 1;
      end
    end
    @(posedge clk); #1;
    if (!we && win == W_DATA) begin
      if (pc == 1) begin
        if (m_cnt < (1 << CNT_W) - 1) m_cnt++;
        if (m_irq && m_thr != 0 && m_cnt >= m_thr) m_ce = 1;
      end else if (pc >= 2) begin
        m_ue = 1; m_ueidx = ix;
      end
    end
  endtask

  task automatic wr(input logic [1:0] w, input int ix, input logic [63:0] d, input string t);
    bus_op(1, w, ix, d, t);
  endtask
  task automatic rd(input logic [1:0] w, input int ix, input string t);
    bus_op(0, w, ix, '0, t);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_data[i] = '0; m_mask[i] = '0; m_good[i] = '0; m_known[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!err_corr_o && !err_uncorr_o && !bus_rvalid, "R1 reset outputs",
        {61'd0, err_corr_o, err_uncorr_o, bus_rvalid}, '0);
    rst_n = 1;
    cmp_on = 1;
    for (int r = 0; r < 8; r++) rd(W_REG, r, "R1 reg after reset");

    // R2: plain data path
    wr(W_DATA, 0, 64'h0123_4567_89AB_CDEF, "R2 write");
    wr(W_DATA, 1, '1, "R2 write");
    wr(W_DATA, 2, 64'h8000_0000_0000_0001, "R2 write");
    wr(W_DATA, 3, '0, "R2 write");
    wr(W_DATA, 5, 64'hA5A5_5A5A_F00F_0FF0, "R2 write");
    for (int i = 0; i < 6; i++) if (i != 4) rd(W_DATA, i, "R2 read");

    // R3: raw alias read (first learns, second is checked)
    rd(W_CHK, 1, "R3 alias read");
    rd(W_CHK, 1, "R3 alias read");

    // R4: gate closed, alias write ignored
    wr(W_CHK, 1, {56'd0, m_good[1] ^ 8'h01}, "R4 gated write");
    rd(W_CHK, 1, "R4 alias unchanged");
    rd(W_DATA, 1, "R4 data clean");
    rd(W_REG, 4, "R4 status clean");

    // R9 register setup
    wr(W_REG, 0, 64'h0100, "R9 ctrl");
    wr(W_REG, 2, 0, "R6 clear counter");
    wr(W_REG, 1, 1, "R9 thr");
    wr(W_REG, 3, 1, "R9 irq");
    for (int r = 0; r < 4; r++) rd(W_REG, r, "R9 readback");

    // R5 single fault, threshold 1
    wr(W_CHK, 1, {56'd0, m_good[1] ^ 8'h01}, "R4 open write");
    rd(W_CHK, 1, "R3 raw shows fault");
    rd(W_DATA, 1, "R5 corrected");
    rd(W_REG, 2, "R6 count one");
    rd(W_REG, 4, "R7 status set");
    rd(W_DATA, 1, "R5 corrected again");
    rd(W_CHK, 1, "R5 not written back");
    wr(W_REG, 4, 0, "R7 write zero");
    rd(W_REG, 4, "R7 still set");
    wr(W_REG, 4, 1, "R7 w1c");
    rd(W_REG, 4, "R7 cleared");

    // R7 threshold 3, overall parity bit fault
    rd(W_CHK, 0, "R3 learn");
    wr(W_CHK, 0, {56'd0, m_good[0] ^ 8'h80}, "R4 inject");
    wr(W_REG, 2, 0, "R6 clear");
    wr(W_REG, 1, 3, "R7 thr3");
    for (int k = 0; k < 3; k++) begin
      rd(W_DATA, 0, "R5 corrected");
      rd(W_REG, 4, "R7 status vs threshold");
    end
    wr(W_REG, 4, 1, "R7 w1c");

    // R7 reporting disabled, R6 saturation
    wr(W_REG, 3, 0, "R7 irq off");
    rd(W_DATA, 0, "R5 corrected");
    rd(W_DATA, 0, "R5 corrected");
    rd(W_REG, 2, "R6 still counts");
    wr(W_REG, 2, 254, "R6 preload");
    for (int k = 0; k < 3; k++) rd(W_DATA, 0, "R5 corrected");
    rd(W_REG, 2, "R6 saturated");

    // R8 double faults
    rd(W_CHK, 2, "R3 learn");
    wr(W_CHK, 2, {56'd0, m_good[2] ^ 8'h03}, "R4 inject");
    rd(W_DATA, 2, "R8 uncorrectable");
    rd(W_REG, 5, "R8 fail index");
    rd(W_REG, 4, "R8 status");
    wr(W_REG, 4, 2, "R8 w1c");
    rd(W_CHK, 5, "R3 learn");
    wr(W_CHK, 5, {56'd0, m_good[5] ^ 8'h90}, "R4 inject");
    rd(W_DATA, 5, "R8 uncorrectable");
    rd(W_REG, 5, "R8 fail index");
    wr(W_REG, 4, 3, "R8 w1c");

    // R2 restore by data write
    wr(W_DATA, 2, 64'h1357_9BDF_2468_ACE0, "R2 rewrite");
    rd(W_DATA, 2, "R2 restored");
    rd(W_REG, 4, "R2 status quiet");

    // R4 gate closed again
    wr(W_REG, 0, 0, "R9 ctrl off");
    wr(W_CHK, 3, 64'h00FF, "R4 gated write");
    rd(W_DATA, 3, "R4 data clean");
    rd(W_REG, 7, "R9 unused reads zero");

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule